// File: doc/BRIEF.md
# Clocked Serial Byte Receiver with Overrun Lock

This block receives serial data that an external master shifts in on its own serial clock. The serial clock and data lines are brought into the system clock domain through a synchronizer. Each rising edge of the serial clock then samples one data bit, most significant bit first. After eight edges the byte goes to a receive data register. A receive-full flag shows that the byte waits for software. Reading the register lowers that flag.

Software arms the receiver in two steps. It raises the receive-enable input, then makes one dummy read of the data register. A byte can finish while the previous byte is still unread. In that case the new byte is thrown away and the earlier byte is kept. An overrun flag is set, and the receiver ignores the serial line until software clears that flag.

A receive interrupt and an error interrupt each have their own enable input.

Top module: `serial_frame_rx`

## Requirements
- R1: Bytes are captured only after `rx_enable_i` is 1 and a `data_rd_i` pulse has been given while it is 1. Before that, serial clock edges leave `rx_full_o` at 0.
- R2: `sdi_i` is sampled on each rising edge of `sclk_i`, first bit into bit 7. After the 8th edge, `rx_data_o` holds the byte and `rx_full_o` is 1, no later than the 3rd system clock edge after the edge reaches `sclk_i`.
- R3: `rx_irq_o` is 1 exactly when `rx_full_o` is 1 and `rx_irq_en_i` is 1.
- R4: A `data_rd_i` pulse clears `rx_full_o` and leaves `rx_data_o` unchanged.
- R5: A byte may complete while `rx_full_o` is 1 and no read is made in that cycle. Then `ovr_o` becomes 1, `rx_data_o` keeps the earlier byte and `rx_full_o` stays 1.
- R6: `err_irq_o` is 1 exactly when `ovr_o` is 1 and `err_irq_en_i` is 1.
- R7: While `ovr_o` is 1, serial edges are ignored. A pulse on `ovr_clr_i` clears `ovr_o`, and the next byte is assembled from its first bit.
- R8: Lowering `rx_enable_i` discards a partly received byte and drops the arming. `rx_full_o`, `ovr_o` and `rx_data_o` are left unchanged.
- R9: After reset, `rx_data_o` is 0 and every flag and interrupt output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock from the external master |
| sdi_i | input | 1 | Serial data in |
| rx_enable_i | input | 1 | Receive enable |
| rx_irq_en_i | input | 1 | Receive interrupt enable |
| err_irq_en_i | input | 1 | Overrun interrupt enable |
| data_rd_i | input | 1 | One-cycle strobe: software reads the data register |
| ovr_clr_i | input | 1 | One-cycle strobe: software writes the overrun flag to 0 |
| rx_data_o | output | DATA_W | Receive data register |
| rx_full_o | output | 1 | Receive-full flag |
| ovr_o | output | 1 | Overrun flag |
| rx_irq_o | output | 1 | Receive interrupt |
| err_irq_o | output | 1 | Overrun interrupt |

## Verification
A serial clock rise becomes visible in the system domain after two synchronizer stages. The byte register and the receive-full flag are loaded on the following edge, so both are due on the third system clock edge after the rise. The bench holds each serial clock level for four system clocks and checks results at a falling system edge after that hold. The strobe inputs act on the next rising edge, and the bench checks their effect at the falling edge that comes one edge later. The interrupt outputs are combinational copies of registered flags, so they are checked in the same sample as their flags.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef enum logic {
    RX_IDLE  = 1'b0,
    RX_ARMED = 1'b1
  } rx_mode_e;
endpackage

// File: rtl/srx_sync_edge.sv
module srx_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic sdi_i,
  output logic rise_o,
  output logic sdi_o
);
  logic [STAGES-1:0] sclk_q;
  logic [STAGES-1:0] sdi_q;
  logic              sclk_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q      <= '0;
      sdi_q       <= '0;
      sclk_prev_q <= 1'b0;
    end else begin
      sclk_q      <= {sclk_q[STAGES-2:0], sclk_i};
      sdi_q       <= {sdi_q[STAGES-2:0], sdi_i};
      sclk_prev_q <= sclk_q[STAGES-1];
    end
  end

  assign rise_o = sclk_q[STAGES-1] & ~sclk_prev_q;
  assign sdi_o  = sdi_q[STAGES-1];
endmodule

// File: rtl/srx_shifter.sv
module srx_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic [DATA_W-1:0] frame_o,
  output logic              done_o
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (clear_i) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (shift_i) begin
      sh_q  <= frame_o;
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  // MSB first: the newest bit enters at bit 0
  assign frame_o = {sh_q[DATA_W-2:0], bit_i};
  assign done_o  = shift_i && (cnt_q == LAST);
endmodule

// File: rtl/srx_status.sv
module srx_status
  import srx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_enable_i,
  input  logic              data_rd_i,
  input  logic              ovr_clr_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] frame_i,
  output logic              active_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_full_o,
  output logic              ovr_o
);
  rx_mode_e          mode_q;
  logic [DATA_W-1:0] data_q;
  logic              full_q;
  logic              ovr_q;
  logic              overrun;
  logic              load;

  assign overrun = done_i && full_q && !data_rd_i;
  assign load    = done_i && !overrun;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= RX_IDLE;
    end else if (!rx_enable_i) begin
      mode_q <= RX_IDLE;
    end else if (data_rd_i) begin
      mode_q <= RX_ARMED;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (load) begin
        data_q <= frame_i;
        full_q <= 1'b1;
      end else if (data_rd_i) begin
        full_q <= 1'b0;
      end
      if (overrun)        ovr_q <= 1'b1;
      else if (ovr_clr_i) ovr_q <= 1'b0;
    end
  end

  assign active_o  = (mode_q == RX_ARMED) && rx_enable_i && !ovr_q;
  assign rx_data_o = data_q;
  assign rx_full_o = full_q;
  assign ovr_o     = ovr_q;
endmodule

// File: rtl/serial_frame_rx.sv
module serial_frame_rx #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic              rx_enable_i,
  input  logic              rx_irq_en_i,
  input  logic              err_irq_en_i,
  input  logic              data_rd_i,
  input  logic              ovr_clr_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_full_o,
  output logic              ovr_o,
  output logic              rx_irq_o,
  output logic              err_irq_o
);
  logic              sclk_rise;
  logic              sdi_s;
  logic              active;
  logic              frm_done;
  logic [DATA_W-1:0] frame;

  srx_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sclk_i (sclk_i),
    .sdi_i  (sdi_i),
    .rise_o (sclk_rise),
    .sdi_o  (sdi_s)
  );

  // any stop (disable or overrun) returns the shifter to bit 0
  srx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (!active),
    .shift_i (sclk_rise && active),
    .bit_i   (sdi_s),
    .frame_o (frame),
    .done_o  (frm_done)
  );

  srx_status #(.DATA_W(DATA_W)) u_status (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rx_enable_i (rx_enable_i),
    .data_rd_i   (data_rd_i),
    .ovr_clr_i   (ovr_clr_i),
    .done_i      (frm_done),
    .frame_i     (frame),
    .active_o    (active),
    .rx_data_o   (rx_data_o),
    .rx_full_o   (rx_full_o),
    .ovr_o       (ovr_o)
  );

  assign rx_irq_o  = rx_full_o & rx_irq_en_i;
  assign err_irq_o = ovr_o & err_irq_en_i;
endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rx_enable_i,
  input logic              rx_irq_en_i,
  input logic              data_rd_i,
  input logic              ovr_clr_i,
  input logic              frm_done,
  input logic [DATA_W-1:0] rx_data_o,
  input logic              rx_full_o,
  input logic              ovr_o,
  input logic              rx_irq_o,
  input logic              err_irq_o
);
  AST_NO_CAPTURE_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_enable_i |=> !$rose(rx_full_o)); // R1
  AST_RX_IRQ_ON_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(rx_full_o) && rx_irq_en_i) |-> rx_irq_o); // R3
  AST_READ_CLEARS_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_rd_i && !frm_done) |=> !rx_full_o); // R4
  AST_OVR_KEEPS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_o) |-> ($stable(rx_data_o) && rx_full_o)); // R5
  AST_ERR_IRQ_NEEDS_OVR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_irq_o |-> ovr_o); // R6
  AST_OVR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_o && !ovr_clr_i) |=> (ovr_o && $stable(rx_data_o))); // R7
endmodule

bind serial_frame_rx srx_checker #(.DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rx_enable_i (rx_enable_i),
  .rx_irq_en_i (rx_irq_en_i),
  .data_rd_i   (data_rd_i),
  .ovr_clr_i   (ovr_clr_i),
  .frm_done    (frm_done),
  .rx_data_o   (rx_data_o),
  .rx_full_o   (rx_full_o),
  .ovr_o       (ovr_o),
  .rx_irq_o    (rx_irq_o),
  .err_irq_o   (err_irq_o)
);

// File: tb/serial_frame_rx_bench.sv
module serial_frame_rx_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sclk_i = 1'b0;
  logic       sdi_i = 1'b0;
  logic       rx_enable_i = 1'b0;
  logic       rx_irq_en_i = 1'b0;
  logic       err_irq_en_i = 1'b0;
  logic       data_rd_i = 1'b0;
  logic       ovr_clr_i = 1'b0;
  logic [7:0] rx_data_o;
  logic       rx_full_o, ovr_o, rx_irq_o, err_irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // {expected irq, irq enable, sent byte, expected data}
  localparam logic [17:0] VEC [5] = '{
    {1'b1, 1'b1, 8'hA5, 8'hA5},
    {1'b0, 1'b0, 8'h3C, 8'h3C},
    {1'b1, 1'b1, 8'h00, 8'h00},
    {1'b0, 1'b0, 8'hFF, 8'hFF},
    {1'b1, 1'b1, 8'h81, 8'h81}
  };

  always #5 clk_i = ~clk_i;

  serial_frame_rx u_serial_frame_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .sclk_i(sclk_i), .sdi_i(sdi_i),
    .rx_enable_i(rx_enable_i), .rx_irq_en_i(rx_irq_en_i),
    .err_irq_en_i(err_irq_en_i), .data_rd_i(data_rd_i), .ovr_clr_i(ovr_clr_i),
    .rx_data_o(rx_data_o), .rx_full_o(rx_full_o), .ovr_o(ovr_o),
    .rx_irq_o(rx_irq_o), .err_irq_o(err_irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  // sends the top n bits of b, MSB first, each level held 4 clocks
  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sdi_i  = b[i];
      sclk_i = 1'b0;
      wait_clk(4);
      sclk_i = 1'b1;
      wait_clk(4);
    end
    sclk_i = 1'b0;
    wait_clk(2);
  endtask

  task automatic pulse_rd();
    data_rd_i = 1'b1;
    wait_clk(1);
    data_rd_i = 1'b0;
    wait_clk(1);
  endtask

  task automatic pulse_clr();
    ovr_clr_i = 1'b1;
    wait_clk(1);
    ovr_clr_i = 1'b0;
    wait_clk(1);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    wait_clk(3);
    rst_ni = 1'b1;
    wait_clk(1);
    // R9 reset state
    check("R9 data", rx_data_o, 0);
    check("R9 flags", {rx_full_o, ovr_o, rx_irq_o, err_irq_o}, 0);

    // R1 enabled but no dummy read yet
    rx_enable_i = 1'b1;
    wait_clk(2);
    send_bits(8'h5A, 8);
    check("R1 unarmed full", rx_full_o, 0);
    pulse_rd();

    for (int v = 0; v < 5; v++) begin
      rx_irq_en_i = VEC[v][16];
      send_bits(VEC[v][15:8], 8);
      check("R2 full", rx_full_o, 1);
      check("R2 data", rx_data_o, VEC[v][7:0]);
      check("R3 irq", rx_irq_o, VEC[v][17]);
      pulse_rd();
      check("R4 full cleared", rx_full_o, 0);
      check("R4 data kept", rx_data_o, VEC[v][7:0]);
      check("R3 irq low", rx_irq_o, 0);
    end

    // R5 / R6 overrun
    err_irq_en_i = 1'b1;
    send_bits(8'h11, 8);
    send_bits(8'h22, 8);
    check("R5 ovr", ovr_o, 1);
    check("R5 data kept", rx_data_o, 8'h11);
    check("R5 full", rx_full_o, 1);
    check("R6 err irq", err_irq_o, 1);
    err_irq_en_i = 1'b0;
    wait_clk(1);
    check("R6 err irq masked", err_irq_o, 0);
    pulse_rd();
    // R7 frozen while overrun
    send_bits(8'h33, 8);
    check("R7 frozen full", rx_full_o, 0);
    check("R7 frozen data", rx_data_o, 8'h11);
    pulse_clr();
    check("R7 ovr cleared", ovr_o, 0);
    send_bits(8'h44, 8);
    check("R7 resumed data", rx_data_o, 8'h44);
    check("R7 resumed full", rx_full_o, 1);
    pulse_rd();

    // R8 abort partial byte
    send_bits(8'hF0, 4);
    rx_enable_i = 1'b0;
    wait_clk(2);
    check("R8 flags after abort", {rx_full_o, ovr_o}, 0);
    rx_enable_i = 1'b1;
    wait_clk(1);
    send_bits(8'h0F, 8);
    check("R8 disarmed", rx_full_o, 0);
    pulse_rd();
    send_bits(8'h96, 8);
    check("R8 fresh byte", rx_data_o, 8'h96);
    rx_enable_i = 1'b0;
    wait_clk(2);
    check("R8 full kept", rx_full_o, 1);
    check("R8 data kept", rx_data_o, 8'h96);

    done = 1'b1;
    finish_run();
  end
endmodule